// File: doc/BRIEF.md
# Binary-Search Motion Orientation Quantizer

This block turns a pair of consecutive fingertip positions into a direction sector. It takes the two points, forms the motion vector, and finds which of sixteen equal 22.5° sectors the vector points into. No divider and no arctangent are used. The search narrows the answer one boundary line at a time: the sign of the horizontal step, the sign of the vertical step, a diagonal magnitude comparison, and a final test against the bisector of the chosen 45° octant. That last test uses two signed multiplications with coefficients from an eight-entry constant table. Along with the sector code, the block outputs a fixed angle value for that sector, which later gesture-matching logic can use.

The input is one valid/ready transfer carrying both points. Each of the four search steps has its own pipeline stage, so a new point pair can be accepted on every cycle. The result shows up on registered outputs with a valid strobe. When the vector is zero there is no direction to report, so the block raises a no-motion flag and repeats the previous sector.

Top module: `motion_orient_quant`

## Requirements
- R1: The motion vector is dx = x1 - x0 and dy = y1 - y0, taken from unsigned coordinates as signed differences, with no overflow across the full coordinate range.
- R2: Sector k (a 4-bit code, 0 to 15) covers angles from 22.5·k° up to but not including 22.5·(k+1)°. Angles are measured counter-clockwise from the +x axis.
- R3: A vector lying exactly on a multiple of 45° goes to the sector on its counter-clockwise side. So (+,0)→0, (a,a)→2, (0,+)→4, (-a,a)→6, (-,0)→8, (-a,-a)→10, (0,-)→12 and (a,-a)→14.
- R4: out_angle is the centre of the reported sector in sixteenths of a degree, that is 360·k + 180.
- R5: When dx = dy = 0, out_still is 1 and out_sector and out_angle repeat the previous result. After reset the previous result is sector 0. For any non-zero vector, out_still is 0.
- R6: Each accepted input produces exactly one result, four clock cycles after the edge that accepts it. Inputs may be accepted on back-to-back cycles.
- R7: in_ready is low while reset is asserted and high after it. While in_valid is low, no result is produced.
- R8: During reset, out_valid is 0, out_sector is 0, out_angle is 180 and out_still is 0.
- R9: Vectors near the odd multiples of 22.5° are resolved by the rotated-bisector test. Their sector agrees with an exact angle computation except within 0.01° of such a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Point pair present |
| in_ready | output | 1 | Block can accept a point pair |
| in_x0 | input | CRD_W | Earlier x coordinate |
| in_y0 | input | CRD_W | Earlier y coordinate |
| in_x1 | input | CRD_W | Later x coordinate |
| in_y1 | input | CRD_W | Later y coordinate |
| out_valid | output | 1 | Result strobe |
| out_sector | output | 4 | Direction sector code |
| out_angle | output | ANG_W | Sector centre angle, 1/16 degree |
| out_still | output | 1 | Zero motion vector |

## Verification
The assertions check on every cycle the things that hold regardless of the data. Results appear exactly four cycles after acceptance. The octant carried into stage three keeps the quadrant found in stage two. The final code keeps the octant from stage three. A no-motion result never changes the sector. Whether the sector is numerically correct can only be shown by the bench scenarios. These compare results against an exact angle calculation over random vectors, the eight 45° ties, extreme coordinates, and vectors placed one unit either side of each rotated bisector.

// File: rtl/orient_pkg.sv
// Package: shared sizes and helpers for the orientation quantizer.
// Assumes the sector count is fixed at 16 (4-bit code, 8 octants).
package orient_pkg;
    localparam int SEC_W = 4;
    localparam int OCT_W = 3;

    // Sector centre angle in sixteenths of a degree (22.5 deg = 360 units).
    function automatic int sector_centre(input logic [SEC_W-1:0] k);
        return int'(k) * 360 + 180;
    endfunction
endpackage

// File: rtl/orient_delta.sv
// Stage 1: forms the motion vector and classifies the sign of dx
// against the x = 0 boundary. Assumes unsigned input coordinates.
module orient_delta #(
    parameter int CRD_W = 12,
    localparam int DW = CRD_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc,
    input  logic [CRD_W-1:0]     x0,
    input  logic [CRD_W-1:0]     y0,
    input  logic [CRD_W-1:0]     x1,
    input  logic [CRD_W-1:0]     y1,
    output logic                 v1,
    output logic signed [DW-1:0] dx1,
    output logic signed [DW-1:0] dy1,
    output logic                 dx_pos1,
    output logic                 dx_zero1
);
    logic signed [DW-1:0] dx_c, dy_c;

    // Zero-extended differences; DW bits cover the full signed range.
    always_comb begin
        dx_c = DW'(x1) - DW'(x0);
        dy_c = DW'(y1) - DW'(y0);
    end

    // Register the vector and the x = 0 sign class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0;
        end else begin
            v1 <= acc;
        end
        dx1      <= dx_c;
        dy1      <= dy_c;
        dx_pos1  <= (dx_c > 0);
        dx_zero1 <= (dx_c == 0);
    end
endmodule

// File: rtl/orient_quadrant.sv
// Stage 2: tests dy against y = 0 and picks a half-open quadrant.
// The quadrant includes its clockwise edge, so axis vectors go counter-clockwise.
module orient_quadrant #(
    parameter int DW = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v1,
    input  logic signed [DW-1:0] dx1,
    input  logic signed [DW-1:0] dy1,
    input  logic                 dx_pos1,
    input  logic                 dx_zero1,
    output logic                 v2,
    output logic signed [DW-1:0] dx2,
    output logic signed [DW-1:0] dy2,
    output logic [1:0]           q2,
    output logic                 still2
);
    logic dy_pos, dy_zero, dx_neg, dy_neg;
    logic [1:0] q_c;

    // Quadrant select from the two sign classes.
    always_comb begin
        dy_pos  = (dy1 > 0);
        dy_zero = (dy1 == 0);
        dx_neg  = !dx_pos1 && !dx_zero1;
        dy_neg  = !dy_pos && !dy_zero;
        if (dx_pos1 && !dy_neg)      q_c = 2'd0;
        else if (!dx_pos1 && dy_pos) q_c = 2'd1;
        else if (dx_neg && !dy_pos)  q_c = 2'd2;
        else                         q_c = 2'd3;
    end

    // Register quadrant, vector and the zero-vector flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2 <= 1'b0;
        end else begin
            v2 <= v1;
        end
        dx2    <= dx1;
        dy2    <= dy1;
        q2     <= q_c;
        still2 <= dx_zero1 && dy_zero;
    end
endmodule

// File: rtl/orient_octant.sv
// Stage 3: compares dy with +dx or -dx (the diagonal chosen by the quadrant)
// to split the quadrant into two octants. Ties on the diagonal go upward.
module orient_octant #(
    parameter int DW = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v2,
    input  logic signed [DW-1:0] dx2,
    input  logic signed [DW-1:0] dy2,
    input  logic [1:0]           q2,
    input  logic                 still2,
    output logic                 v3,
    output logic signed [DW-1:0] dx3,
    output logic signed [DW-1:0] dy3,
    output logic [2:0]           oct3,
    output logic                 still3
);
    logic upper;

    // Diagonal test in the quadrant's own rotated frame.
    always_comb begin
        unique case (q2)
            2'd0:    upper = (dy2 >= dx2);
            2'd1:    upper = (-dx2 >= dy2);
            2'd2:    upper = (dx2 >= dy2);
            default: upper = (dx2 >= -dy2);
        endcase
    end

    // Register the octant index and pass the vector on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v3 <= 1'b0;
        end else begin
            v3 <= v2;
        end
        dx3    <= dx2;
        dy3    <= dy2;
        oct3   <= {q2, upper};
        still3 <= still2;
    end

    // R2: octant keeps the quadrant from the previous stage
    a_r2_octant_from_quadrant: assert property (@(posedge clk) disable iff (!rst_n)
        v3 && !still3 |-> oct3[2:1] == $past(q2));
endmodule

// File: rtl/orient_refine.sv
// Stage 4: tests the vector against the bisector of its octant,
// cos(m)*dy - sin(m)*dx >= 0, with two multipliers and an 8-entry table.
// Registers the sector, its centre angle, and the no-motion result.
module orient_refine
    import orient_pkg::*;
#(
    parameter int DW    = 13,
    parameter int FRAC  = 14,
    parameter int ANG_W = 13,
    localparam int CW   = FRAC + 2,
    localparam int PW   = DW + CW + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    v3,
    input  logic signed [DW-1:0]    dx3,
    input  logic signed [DW-1:0]    dy3,
    input  logic [OCT_W-1:0]        oct3,
    input  logic                    still3,
    output logic                    out_valid,
    output logic [SEC_W-1:0]        out_sector,
    output logic [ANG_W-1:0]        out_angle,
    output logic                    out_still
);
    localparam real COS_M = 0.9238795325112867;
    localparam real SIN_M = 0.3826834323650898;
    localparam logic signed [CW-1:0] KC = CW'(int'(COS_M * (2.0 ** FRAC)));
    localparam logic signed [CW-1:0] KS = CW'(int'(SIN_M * (2.0 ** FRAC)));

    logic signed [CW-1:0] coef_a, coef_b;
    logic signed [PW-1:0] prod_a, prod_b, margin;
    logic [SEC_W-1:0]     sec_c;

    // Bisector coefficients: A = cos, B = sin of 22.5 + 45*oct degrees.
    always_comb begin
        unique case (oct3)
            3'd0:    begin coef_a =  KC; coef_b =  KS; end
            3'd1:    begin coef_a =  KS; coef_b =  KC; end
            3'd2:    begin coef_a = -KS; coef_b =  KC; end
            3'd3:    begin coef_a = -KC; coef_b =  KS; end
            3'd4:    begin coef_a = -KC; coef_b = -KS; end
            3'd5:    begin coef_a = -KS; coef_b = -KC; end
            3'd6:    begin coef_a =  KS; coef_b = -KC; end
            default: begin coef_a =  KC; coef_b = -KS; end
        endcase
    end

    // Two multipliers and the signed margin against the rotated boundary.
    always_comb begin
        prod_a = PW'(coef_a) * PW'(dy3);
        prod_b = PW'(coef_b) * PW'(dx3);
        margin = prod_a - prod_b;
        sec_c  = {oct3, (margin >= 0)};
    end

    // Output register; a zero vector holds the previous sector and angle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sector <= '0;
            out_angle  <= ANG_W'(sector_centre('0));
            out_still  <= 1'b0;
        end else begin
            out_valid <= v3;
            if (v3) begin
                out_still <= still3;
                if (!still3) begin
                    out_sector <= sec_c;
                    out_angle  <= ANG_W'(sector_centre(sec_c));
                end
            end
        end
    end

    // R5: no-motion result repeats the previous sector
    a_r5_still_holds: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_still |-> out_sector == $past(out_sector));
    // R2: sector code refines the octant from stage three
    a_r2_sector_from_octant: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_still |-> out_sector[3:1] == $past(oct3));
endmodule

// File: rtl/motion_orient_quant.sv
// Top: four-stage binary-search orientation quantizer. Accepts one point
// pair per cycle once out of reset and produces a registered sector code.
module motion_orient_quant
    import orient_pkg::*;
#(
    parameter int CRD_W = 12,
    parameter int FRAC  = 14,
    parameter int ANG_W = 13,
    localparam int DW   = CRD_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [CRD_W-1:0] in_x0,
    input  logic [CRD_W-1:0] in_y0,
    input  logic [CRD_W-1:0] in_x1,
    input  logic [CRD_W-1:0] in_y1,
    output logic             out_valid,
    output logic [SEC_W-1:0] out_sector,
    output logic [ANG_W-1:0] out_angle,
    output logic             out_still
);
    logic acc;
    logic v1, v2, v3;
    logic signed [DW-1:0] dx1, dy1, dx2, dy2, dx3, dy3;
    logic dx_pos1, dx_zero1, still2, still3;
    logic [1:0] q2;
    logic [OCT_W-1:0] oct3;

    // Ready rises the cycle after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) in_ready <= 1'b0;
        else        in_ready <= 1'b1;
    end

    assign acc = in_valid && in_ready;

    orient_delta #(.CRD_W(CRD_W)) u_delta (
        .clk(clk), .rst_n(rst_n), .acc(acc),
        .x0(in_x0), .y0(in_y0), .x1(in_x1), .y1(in_y1),
        .v1(v1), .dx1(dx1), .dy1(dy1), .dx_pos1(dx_pos1), .dx_zero1(dx_zero1)
    );

    orient_quadrant #(.DW(DW)) u_quad (
        .clk(clk), .rst_n(rst_n), .v1(v1), .dx1(dx1), .dy1(dy1),
        .dx_pos1(dx_pos1), .dx_zero1(dx_zero1),
        .v2(v2), .dx2(dx2), .dy2(dy2), .q2(q2), .still2(still2)
    );

    orient_octant #(.DW(DW)) u_oct (
        .clk(clk), .rst_n(rst_n), .v2(v2), .dx2(dx2), .dy2(dy2),
        .q2(q2), .still2(still2),
        .v3(v3), .dx3(dx3), .dy3(dy3), .oct3(oct3), .still3(still3)
    );

    orient_refine #(.DW(DW), .FRAC(FRAC), .ANG_W(ANG_W)) u_refine (
        .clk(clk), .rst_n(rst_n), .v3(v3), .dx3(dx3), .dy3(dy3),
        .oct3(oct3), .still3(still3),
        .out_valid(out_valid), .out_sector(out_sector),
        .out_angle(out_angle), .out_still(out_still)
    );

    // R6: one result exactly four cycles after each accepted input
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(acc, 4));
endmodule

// File: tb/test_motion_orient_quant.sv
// Scoreboard bench: the driver queues exact-angle expectations,
// the monitor pops and compares them when results appear.
module test_motion_orient_quant;
    localparam int CRD_W = 12;
    localparam int ANG_W = 13;
    localparam real PI = 3.14159265358979323846;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [CRD_W-1:0] in_x0 = '0, in_y0 = '0, in_x1 = '0, in_y1 = '0;
    logic out_valid;
    logic [3:0] out_sector;
    logic [ANG_W-1:0] out_angle;
    logic out_still;

    int n_checks = 0;
    int n_errors = 0;
    int n_sent = 0;
    int n_seen = 0;
    int last_sec = 0;
    bit done = 1'b0;

    typedef struct {
        int    sec;
        int    alt;
        bit    still;
        string req;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    motion_orient_quant #(.CRD_W(CRD_W), .ANG_W(ANG_W)) i_motion_orient_quant (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_x0(in_x0), .in_y0(in_y0), .in_x1(in_x1), .in_y1(in_y1),
        .out_valid(out_valid), .out_sector(out_sector),
        .out_angle(out_angle), .out_still(out_still)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected sector from the R2/R3 definition; alt is the tolerated neighbour (R9).
    task automatic model(input int dx, input int dy, output int sec, output int alt);
        real deg, r;
        alt = -1;
        if (dy == 0)            sec = (dx > 0) ? 0 : 8;
        else if (dx == 0)       sec = (dy > 0) ? 4 : 12;
        else if (dx == dy)      sec = (dx > 0) ? 2 : 10;
        else if (dx == -dy)     sec = (dx < 0) ? 6 : 14;
        else begin
            deg = $atan2(real'(dy), real'(dx)) * 180.0 / PI;
            if (deg < 0.0) deg = deg + 360.0;
            sec = int'($floor(deg / 22.5));
            if (sec > 15) sec = 15;
            r = deg - 22.5 * sec;
            if (r < 0.01)       alt = (sec + 15) % 16;
            else if (r > 22.49) alt = (sec + 1) % 16;
        end
    endtask

    // Driver: presents one point pair at a falling edge and queues its result.
    task automatic send_pts(input int x0, input int y0, input int x1, input int y1,
                            input string req);
        exp_t e;
        int dx, dy;
        dx = x1 - x0;
        dy = y1 - y0;
        if (dx == 0 && dy == 0) begin
            e.sec = last_sec; e.alt = -1; e.still = 1'b1;
        end else begin
            model(dx, dy, e.sec, e.alt);
            e.still = 1'b0;
            last_sec = e.sec;
        end
        e.req = req;
        @(negedge clk);
        in_x0 = CRD_W'(x0); in_y0 = CRD_W'(y0);
        in_x1 = CRD_W'(x1); in_y1 = CRD_W'(y1);
        in_valid = 1'b1;
        sb.push_back(e);
        n_sent++;
    endtask

    task automatic send_vec(input int dx, input int dy, input string req);
        send_pts(2048 - dx / 2, 2048 - dy / 2, 2048 - dx / 2 + dx, 2048 - dy / 2 + dy, req);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_x0 = CRD_W'(i * 7); in_x1 = CRD_W'(i * 13);
        end
    endtask

    // Monitor: pops an expectation for every result strobe.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_seen++;
            if (sb.size() == 0) begin
                check(1'b0, "R7 unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(out_sector == 4'(e.sec) || (e.alt >= 0 && out_sector == 4'(e.alt)),
                      {e.req, " sector"}, int'(out_sector), e.sec);
                check(out_angle == ANG_W'(int'(out_sector) * 360 + 180),
                      "R4 angle", int'(out_angle), int'(out_sector) * 360 + 180);
                check(out_still == e.still, {e.req, " still flag"}, int'(out_still), int'(e.still));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R8 / R7: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R8 out_valid in reset", int'(out_valid), 0);
        check(out_sector == 4'd0, "R8 sector in reset", int'(out_sector), 0);
        check(out_angle == ANG_W'(180), "R8 angle in reset", int'(out_angle), 180);
        check(out_still == 1'b0, "R8 still in reset", int'(out_still), 0);
        check(in_ready == 1'b0, "R7 ready low in reset", int'(in_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R7 ready after reset", int'(in_ready), 1);

        // R5: zero vector first after reset keeps sector 0
        send_pts(100, 200, 100, 200, "R5 first still");
        idle(6);

        // R3: the eight 45-degree ties
        send_vec(5, 0, "R3 +x axis");
        send_vec(3, 3, "R3 diag 45");
        send_vec(0, 7, "R3 +y axis");
        send_vec(-9, 9, "R3 diag 135");
        send_vec(-4, 0, "R3 -x axis");
        send_vec(-6, -6, "R3 diag 225");
        send_vec(0, -2, "R3 -y axis");
        send_vec(8, -8, "R3 diag 315");
        idle(6);

        // R1: extreme coordinates, full-range differences
        send_pts(0, 0, 4095, 4095, "R1 max positive");
        send_pts(4095, 0, 0, 0, "R1 max negative dx");
        send_pts(0, 4095, 4095, 0, "R1 opposite corners");
        send_pts(4095, 4095, 0, 1, "R1 near 225");
        idle(6);

        // R5: zero vector after motion repeats the previous sector
        send_vec(10, 5, "R5 motion before still");
        send_pts(3000, 17, 3000, 17, "R5 still repeats");
        send_vec(-10, -1, "R5 motion after still");
        send_pts(0, 0, 0, 0, "R5 still at origin");
        idle(6);

        // R9: one unit either side of each rotated bisector
        for (int j = 0; j < 8; j++) begin
            for (int k = 0; k < 3; k++) begin
                real ang, rad;
                int bx, by;
                ang = (22.5 + 45.0 * j) * PI / 180.0;
                rad = (k == 0) ? 37.0 : ((k == 1) ? 900.0 : 1990.0);
                bx = int'(rad * $cos(ang));
                by = int'(rad * $sin(ang));
                for (int d = -1; d <= 1; d++) begin
                    send_vec(bx, by + d, "R9 bisector");
                    send_vec(bx + d, by, "R9 bisector");
                end
            end
        end
        idle(6);

        // R2 / R6: random pairs back to back at full rate
        for (int i = 0; i < 400; i++) begin
            send_pts(int'($urandom_range(4095)), int'($urandom_range(4095)),
                     int'($urandom_range(4095)), int'($urandom_range(4095)), "R2 random");
        end
        // R2: short random vectors
        for (int i = 0; i < 200; i++) begin
            send_vec(int'($urandom_range(40)) - 20, int'($urandom_range(40)) - 20, "R2 short");
        end
        idle(8);

        // R6 / R7: all results returned, and idle inputs make none
        check(n_seen == n_sent, "R6 result count", n_seen, n_sent);
        idle(20);
        check(n_seen == n_sent, "R7 no result while idle", n_seen, n_sent);
        check(sb.size() == 0, "R6 scoreboard drained", sb.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule